// File: doc/BRIEF.md
# Packed 32-by-16 Divide Unit

A multi-cycle divider that divides a 32-bit dividend by a 16-bit divisor. A mode input picks unsigned or two's-complement operation for each request. The answer comes back as one 32-bit word. The quotient sits in the low half and the remainder in the high half. Alongside it the unit returns negative, zero, overflow and carry flags, plus a strobe for a zero divisor.

A request is a one-cycle `start_i` pulse, with the operands and the mode held valid in that cycle. The unit first spends one cycle screening the request. A zero divisor, or a quotient too wide for 16 bits, ends the request at once. In that case the result word is the dividend, left untouched. Otherwise a restoring shift-subtract core produces one quotient bit per clock. A final cycle then applies the sign corrections and registers the outputs. `done_o` marks the cycle in which a new result is valid. The outputs hold their values until the next completion.

Top module: `pdiv_unit`

## Requirements
- R1: In unsigned mode (`signed_i`=0), `result_o[15:0]` is the floor quotient and `result_o[31:16]` is the remainder.
- R2: In signed mode (`signed_i`=1), both operands are two's complement. The quotient is truncated toward zero and returned as a 16-bit two's-complement value in `result_o[15:0]`.
- R3: In signed mode a nonzero remainder in `result_o[31:16]` has the sign of the dividend.
- R4: A zero divisor ends the request after one cycle. `div_zero_o` and `done_o` rise together, `result_o` equals the dividend, and all four flags are 0. A zero divisor takes precedence over overflow.
- R5: In unsigned mode, a dividend whose upper 16 bits are greater than or equal to the divisor is an overflow. The result is `flag_v_o`=1, `flag_n_o`=`flag_z_o`=`flag_c_o`=0, and `result_o` equals the dividend.
- R6: In signed mode, a true quotient outside -32768..32767 is an overflow with the same outputs as R5. This includes the case of a dividend of -2^31.
- R7: On a normal completion, `flag_n_o` equals quotient bit 15 and `flag_z_o` is 1 exactly when the quotient is 0. `flag_v_o` and `flag_c_o` are 0.
- R8: `done_o` is a one-cycle pulse. Count from the clock edge that samples `start_i`. A normal request raises `done_o` after 18 further edges. A zero-divisor or overflow request raises it after 1 edge.
- R9: A `start_i` pulse while a request is in progress is ignored. It changes neither the running result nor the number of `done_o` pulses.
- R10: After reset, `result_o`, all flags, `div_zero_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request pulse |
| signed_i | input | 1 | 1 = two's-complement mode, 0 = unsigned |
| dividend_i | input | 32 | Dividend, sampled with `start_i` |
| divisor_i | input | 16 | Divisor, sampled with `start_i` |
| result_o | output | 32 | Remainder in [31:16], quotient in [15:0] |
| flag_n_o | output | 1 | Quotient negative |
| flag_z_o | output | 1 | Quotient zero |
| flag_v_o | output | 1 | Overflow, request aborted |
| flag_c_o | output | 1 | Carry, always 0 |
| div_zero_o | output | 1 | Zero-divisor strobe, coincides with `done_o` |
| done_o | output | 1 | Completion pulse |

## Verification
A corrupted partial remainder or iteration count in the core stays hidden until completion. It then shows as a wrong packed word, or as a `done_o` edge earlier or later than the fixed 18. That is at most 18 cycles after the request. A wrong screening decision shows after a single edge: a normal request is cut short with V set, or an overflowing one runs the full length. A wrong sign-correction state shows only on signed requests with mixed signs. For that reason the vectors pair every sign combination with the -2^31 and -32768 extremes.

// File: rtl/pdiv_pkg.sv
`timescale 1ns/1ps
package pdiv_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CHECK = 2'd1,
      ST_RUN   = 2'd2,
      ST_FIX   = 2'd3
   } pdiv_state_e;
endpackage

// File: rtl/pdiv_prep.sv
`timescale 1ns/1ps
// Operand screening: magnitudes, sign plan, zero divisor and early overflow.
module pdiv_prep #(
   parameter int unsigned W         = 16,
   parameter bit          SIGNED_EN = 1'b1
) (
   input  logic             signed_i,
   input  logic [2*W-1:0]   num_i,
   input  logic [W-1:0]     den_i,
   output logic [2*W-1:0]   num_mag_o,
   output logic [W-1:0]     den_mag_o,
   output logic             q_neg_o,
   output logic             r_neg_o,
   output logic             dz_o,
   output logic             ovf_o
);
   localparam int unsigned LW = 2*W + 2;

   logic [LW-1:0] limit;

   generate
      if (SIGNED_EN) begin : g_signed
         logic sa, sb;
         assign sa        = signed_i & num_i[2*W-1];
         assign sb        = signed_i & den_i[W-1];
         assign num_mag_o = sa ? (~num_i + 1'b1) : num_i;
         assign den_mag_o = sb ? (~den_i + 1'b1) : den_i;
         assign q_neg_o   = sa ^ sb;
         assign r_neg_o   = sa;
         // quotient magnitude bound: 2^(W-1)-1 same signs, 2^(W-1) mixed signs
         always_comb begin
            if (signed_i)
               limit = (LW'(den_mag_o) << (W-1)) + (q_neg_o ? LW'(den_mag_o) : LW'(0));
            else
               limit = LW'(den_mag_o) << W;
         end
      end else begin : g_unsigned
         logic unused_mode;
         assign unused_mode = signed_i;
         assign num_mag_o   = num_i;
         assign den_mag_o   = den_i;
         assign q_neg_o     = 1'b0;
         assign r_neg_o     = 1'b0;
         assign limit       = LW'(den_i) << W;
      end
   endgenerate

   assign dz_o  = (den_i == '0);
   assign ovf_o = !dz_o && (LW'(num_mag_o) >= limit);
endmodule

// File: rtl/pdiv_core.sv
`timescale 1ns/1ps
// Restoring shift-subtract core, one quotient bit per clock.
module pdiv_core #(
   parameter int unsigned W = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load_i,
   input  logic [2*W-1:0] num_i,
   input  logic [W-1:0]   den_i,
   output logic [W-1:0]   rem_o,
   output logic [W-1:0]   quo_o,
   output logic           last_o
);
   localparam int unsigned CW = $clog2(W);

   logic [CW-1:0] cnt_q;
   logic          run_q;
   logic [W-1:0]  rem_q, quo_q, den_q;
   logic [W:0]    trial, diff;
   logic          take;

   always_comb begin
      trial  = {rem_q, quo_q[W-1]};
      diff   = trial - {1'b0, den_q};
      take   = (trial >= {1'b0, den_q});
      last_o = run_q && (cnt_q == CW'(W-1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         quo_q <= '0;
         den_q <= '0;
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (load_i) begin
         rem_q <= num_i[2*W-1:W];
         quo_q <= num_i[W-1:0];
         den_q <= den_i;
         cnt_q <= '0;
         run_q <= 1'b1;
      end else if (run_q) begin
         rem_q <= take ? diff[W-1:0] : trial[W-1:0];
         quo_q <= {quo_q[W-2:0], take};
         cnt_q <= cnt_q + 1'b1;
         if (last_o) run_q <= 1'b0;
      end
   end

   assign rem_o = rem_q;
   assign quo_o = quo_q;

   // R1: screening guarantees the partial remainder stays below the divisor
   a_r1_partial_below: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (rem_q < den_q));
endmodule

// File: rtl/pdiv_fix.sv
`timescale 1ns/1ps
// Sign correction and quotient flags.
module pdiv_fix #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0]   rem_mag_i,
   input  logic [W-1:0]   quo_mag_i,
   input  logic           q_neg_i,
   input  logic           r_neg_i,
   output logic [2*W-1:0] result_o,
   output logic           n_o,
   output logic           z_o
);
   logic [W-1:0] quo, rem;

   always_comb begin
      quo      = q_neg_i ? (~quo_mag_i + 1'b1) : quo_mag_i;
      rem      = r_neg_i ? (~rem_mag_i + 1'b1) : rem_mag_i;
      result_o = {rem, quo};
      n_o      = quo[W-1];
      z_o      = (quo == '0);
   end
endmodule

// File: rtl/pdiv_unit.sv
`timescale 1ns/1ps
module pdiv_unit #(
   parameter int unsigned W         = 16,
   parameter bit          SIGNED_EN = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  logic           signed_i,
   input  logic [2*W-1:0] dividend_i,
   input  logic [W-1:0]   divisor_i,
   output logic [2*W-1:0] result_o,
   output logic           flag_n_o,
   output logic           flag_z_o,
   output logic           flag_v_o,
   output logic           flag_c_o,
   output logic           div_zero_o,
   output logic           done_o
);
   import pdiv_pkg::*;

   localparam int unsigned RW = 2*W;

   generate
      if (W < 4) begin : g_bad_width
         $error("pdiv_unit: W must be at least 4");
      end
   endgenerate

   pdiv_state_e    state_q;
   logic [RW-1:0]  op_a_q;
   logic [W-1:0]   op_b_q;
   logic           op_s_q;

   logic [RW-1:0]  num_mag;
   logic [W-1:0]   den_mag, rem_mag, quo_mag;
   logic           q_neg, r_neg, dz, ovf, core_load, core_last;
   logic [RW-1:0]  fix_res;
   logic           fix_n, fix_z;

   pdiv_prep #(.W(W), .SIGNED_EN(SIGNED_EN)) prep_i (
      .signed_i (op_s_q),  .num_i   (op_a_q),  .den_i   (op_b_q),
      .num_mag_o(num_mag), .den_mag_o(den_mag),
      .q_neg_o  (q_neg),   .r_neg_o (r_neg),
      .dz_o     (dz),      .ovf_o   (ovf)
   );

   assign core_load = (state_q == ST_CHECK) && !dz && !ovf;

   pdiv_core #(.W(W)) core_i (
      .clk   (clk),      .rst_n (rst_n),   .load_i(core_load),
      .num_i (num_mag),  .den_i (den_mag),
      .rem_o (rem_mag),  .quo_o (quo_mag), .last_o(core_last)
   );

   pdiv_fix #(.W(W)) fix_i (
      .rem_mag_i(rem_mag), .quo_mag_i(quo_mag),
      .q_neg_i  (q_neg),   .r_neg_i  (r_neg),
      .result_o (fix_res), .n_o      (fix_n), .z_o(fix_z)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         op_a_q     <= '0;
         op_b_q     <= '0;
         op_s_q     <= 1'b0;
         result_o   <= '0;
         flag_n_o   <= 1'b0;
         flag_z_o   <= 1'b0;
         flag_v_o   <= 1'b0;
         div_zero_o <= 1'b0;
         done_o     <= 1'b0;
      end else begin
         done_o     <= 1'b0;
         div_zero_o <= 1'b0;
         case (state_q)
            ST_IDLE: if (start_i) begin
               op_a_q  <= dividend_i;
               op_b_q  <= divisor_i;
               op_s_q  <= signed_i;
               state_q <= ST_CHECK;
            end
            ST_CHECK: if (dz || ovf) begin
               result_o   <= op_a_q;
               flag_n_o   <= 1'b0;
               flag_z_o   <= 1'b0;
               flag_v_o   <= ovf;
               div_zero_o <= dz;
               done_o     <= 1'b1;
               state_q    <= ST_IDLE;
            end else begin
               state_q <= ST_RUN;
            end
            ST_RUN: if (core_last) state_q <= ST_FIX;
            ST_FIX: begin
               result_o <= fix_res;
               flag_n_o <= fix_n;
               flag_z_o <= fix_z;
               flag_v_o <= 1'b0;
               done_o   <= 1'b1;
               state_q  <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign flag_c_o = 1'b0;

   // R8: completion is a single-cycle pulse
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R4: zero-divisor strobe only with completion and never with overflow
   a_r4_dz_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      div_zero_o |-> (done_o && !flag_v_o));
   // R5: aborted request returns the captured dividend
   a_r5_ovf_keeps_dest: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && flag_v_o) |-> (result_o == op_a_q));
   // R9: operands cannot be replaced while a request is in progress
   a_r9_busy_holds_ops: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |=> ($stable(op_a_q) && $stable(op_b_q) && $stable(op_s_q)));
   // R3: signed remainder follows the dividend sign
   a_r3_rem_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (SIGNED_EN && done_o && op_s_q && !flag_v_o && !div_zero_o && (result_o[RW-1:W] != '0))
         |-> (result_o[RW-1] == op_a_q[RW-1]));
   // R7: zero flag tracks the returned quotient
   a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !flag_v_o && !div_zero_o) |-> (flag_z_o == (result_o[W-1:0] == '0)));
endmodule

// File: tb/pdiv_unit_tb_top.sv
`timescale 1ns/1ps
module pdiv_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        signed_i = 1'b0;
   logic [31:0] dividend_i = '0;
   logic [15:0] divisor_i = '0;
   logic [31:0] result_o;
   logic        flag_n_o, flag_z_o, flag_v_o, flag_c_o, div_zero_o, done_o;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;   // 125 MHz

   pdiv_unit dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
      .dividend_i(dividend_i), .divisor_i(divisor_i), .result_o(result_o),
      .flag_n_o(flag_n_o), .flag_z_o(flag_z_o), .flag_v_o(flag_v_o),
      .flag_c_o(flag_c_o), .div_zero_o(div_zero_o), .done_o(done_o)
   );

   typedef struct packed {
      logic        sgn;
      logic [31:0] a;
      logic [15:0] b;
      logic [31:0] res;
      logic [3:0]  nzvc;
      logic        dz;
      logic [7:0]  lat;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 32'd100,       16'd7,     32'h0002_000E, 4'b0000, 1'b0, 8'd18}, // R1
      '{1'b0, 32'h0000_FFFF, 16'h0001,  32'h0000_FFFF, 4'b1000, 1'b0, 8'd18}, // R1 R7 N
      '{1'b0, 32'd5,         16'd9,     32'h0005_0000, 4'b0100, 1'b0, 8'd18}, // R1 R7 Z
      '{1'b0, 32'h0001_0000, 16'h0001,  32'h0001_0000, 4'b0010, 1'b0, 8'd1 }, // R5 hi == divisor
      '{1'b0, 32'h1234_5678, 16'hFFFF,  32'h68AC_1234, 4'b0000, 1'b0, 8'd18}, // R1
      '{1'b1, 32'hFFFF_FFF9, 16'h0002,  32'hFFFF_FFFD, 4'b1000, 1'b0, 8'd18}, // R2 R3 -7/2
      '{1'b1, 32'h0000_0007, 16'hFFFE,  32'h0001_FFFD, 4'b1000, 1'b0, 8'd18}, // R2 R3 7/-2
      '{1'b1, 32'hFFFF_FFF9, 16'hFFFE,  32'hFFFF_0003, 4'b0000, 1'b0, 8'd18}, // R2 R3 -7/-2
      '{1'b1, 32'hFFFF_8000, 16'h0001,  32'h0000_8000, 4'b1000, 1'b0, 8'd18}, // R2 q=-32768
      '{1'b1, 32'h0000_8000, 16'h0001,  32'h0000_8000, 4'b0010, 1'b0, 8'd1 }, // R6 q=+32768
      '{1'b1, 32'h8000_0000, 16'hFFFF,  32'h8000_0000, 4'b0010, 1'b0, 8'd1 }, // R6 -2^31/-1
      '{1'b1, 32'h8000_0000, 16'h8000,  32'h8000_0000, 4'b0010, 1'b0, 8'd1 }, // R6 -2^31/-32768
      '{1'b1, 32'hC000_0000, 16'h8000,  32'hC000_0000, 4'b0010, 1'b0, 8'd1 }, // R6 q=+32768
      '{1'b1, 32'hC000_0001, 16'h8000,  32'h8001_7FFF, 4'b0000, 1'b0, 8'd18}, // R2 R3 q=32767
      '{1'b1, 32'h0000_0000, 16'hFFFB,  32'h0000_0000, 4'b0100, 1'b0, 8'd18}, // R2 R7 Z
      '{1'b0, 32'd1234,      16'h0000,  32'h0000_04D2, 4'b0000, 1'b1, 8'd1 }, // R4
      '{1'b1, 32'h4000_0000, 16'h8000,  32'h0000_8000, 4'b1000, 1'b0, 8'd18}, // R2 q=-32768 bound
      '{1'b0, 32'h0000_FFF9, 16'h0002,  32'h0001_7FFC, 4'b0000, 1'b0, 8'd18}  // R1 no sign in unsigned
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // drive one request; return latency in edges after the sampling edge
   task automatic run_op(input logic sgn, input logic [31:0] a, input logic [15:0] b,
                         output int lat);
      @(negedge clk);
      signed_i = sgn; dividend_i = a; divisor_i = b; start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      lat = 0;
      while (!done_o && lat < 40) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : main
      int lat;
      string tag;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10: reset state
      chk(result_o == 32'h0, "R10", "result", result_o, 32'h0);
      chk({flag_n_o, flag_z_o, flag_v_o, flag_c_o} == 4'b0, "R10", "flags",
          {28'h0, flag_n_o, flag_z_o, flag_v_o, flag_c_o}, 32'h0);
      chk(!done_o && !div_zero_o, "R10", "done/dz", {30'h0, done_o, div_zero_o}, 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         run_op(VEC[i].sgn, VEC[i].a, VEC[i].b, lat);
         if (VEC[i].dz)            tag = "R4";
         else if (VEC[i].nzvc[1])  tag = VEC[i].sgn ? "R6" : "R5";
         else                      tag = VEC[i].sgn ? "R2" : "R1";
         chk(result_o == VEC[i].res, tag, $sformatf("vec%0d result", i), result_o, VEC[i].res);
         chk({flag_n_o, flag_z_o, flag_v_o, flag_c_o} == VEC[i].nzvc,
             (VEC[i].nzvc[1] || VEC[i].dz) ? tag : "R7", $sformatf("vec%0d nzvc", i),
             {28'h0, flag_n_o, flag_z_o, flag_v_o, flag_c_o}, {28'h0, VEC[i].nzvc});
         chk(div_zero_o == VEC[i].dz, "R4", $sformatf("vec%0d dz strobe", i),
             {31'h0, div_zero_o}, {31'h0, VEC[i].dz});
         chk(lat == int'(VEC[i].lat), "R8", $sformatf("vec%0d latency", i), lat, VEC[i].lat);
         if (VEC[i].sgn && !VEC[i].nzvc[1] && !VEC[i].dz && result_o[31:16] != 16'h0)
            chk(result_o[31] == VEC[i].a[31], "R3", $sformatf("vec%0d rem sign", i),
                {31'h0, result_o[31]}, {31'h0, VEC[i].a[31]});
         @(negedge clk);
         chk(!done_o, "R8", $sformatf("vec%0d done width", i), {31'h0, done_o}, 32'h0);
      end

      // R4: signed zero divisor wins over what would be overflow
      run_op(1'b1, 32'hFFFF_0000, 16'h0000, lat);
      chk(div_zero_o && !flag_v_o, "R4", "signed dz precedence",
          {30'h0, div_zero_o, flag_v_o}, 32'h2);
      chk(result_o == 32'hFFFF_0000, "R4", "signed dz dest", result_o, 32'hFFFF_0000);

      // R9: second start during a run is ignored
      @(negedge clk);
      signed_i = 1'b0; dividend_i = 32'd100; divisor_i = 16'd7; start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      repeat (3) @(negedge clk);
      dividend_i = 32'h0001_0000; divisor_i = 16'h0001; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      lat = 0;
      while (!done_o && lat < 40) begin
         @(negedge clk);
         lat++;
      end
      chk(result_o == 32'h0002_000E && !flag_v_o, "R9", "busy start result",
          result_o, 32'h0002_000E);
      begin
         int extra = 0;
         for (int k = 0; k < 25; k++) begin
            @(negedge clk);
            if (done_o) extra++;
         end
         chk(extra == 0, "R9", "no extra done", extra, 0);
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule